// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block decides which of nine external masters, or the bridge itself, owns a shared downstream bus. Each external requester has an enable bit and a group-select bit. Enabled requests in the high group take turns in a fair rotation. The whole low group holds one turn in that rotation. Inside that turn, the low-group members take turns in a rotation of their own. This stops a busy high group from locking out low-priority masters. When an input strap is low, every grant stays off so that an arbiter outside the chip can drive the bus instead.

The grant is registered. It may move only while the bus is idle or when the current owner has released its request or lost its enable. When no enabled request is pending, the grant rests on the bridge's own line. The register decode is outside the block: the enable and group bits arrive as plain configuration inputs.

Top module: `sbarb_top`

## Requirements
- R1: While `arb_en` is low, every grant output is low in the same cycle. After `arb_en` returns high, arbitration resumes at the next clock edge.
- R2: An external requester whose `en_mask` bit is 0 never sees its grant high. This includes a current owner: its grant drops in the cycle its enable is cleared.
- R3: At most one of the ten grant outputs (`gnt_ext` bits and `gnt_own`) is high in any cycle.
- R4: The high-priority rotation is an ordered ring: external bit 0 up to bit N_EXT-1, then the bridge line, then one slot for the low group. The next owner is the first pending member after the previous high-ring winner. `hi_grp` bit = 1 puts a requester in the high group.
- R5: When the low-group slot wins, the grant goes to the first pending low-group requester (`hi_grp` bit = 0) with a higher index than the last low-group winner, wrapping around past the top index.
- R6: With all nine external lines requesting and only one in the low group, that requester is granted within N_EXT+1 consecutive arbitration decisions.
- R7: While `bus_idle` is low and the current owner keeps its request and enable, the grant does not change.
- R8: When the current owner drops its request, the grant moves at the next edge even while `bus_idle` is low.
- R9: When no enabled external request and no bridge request is pending, `gnt_own` is high and all `gnt_ext` bits are low.
- R10: After reset, the grant rests on `gnt_own`, and both rotations search first from index 0.
- R11: The grant is registered: a request becomes visible on the grant outputs one clock edge after it qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Strap; 1 = internal arbiter active, 0 = all grants off |
| bus_idle | input | 1 | 1 when the shared bus carries no transaction |
| req_ext | input | N_EXT | Request lines of the external masters |
| req_own | input | 1 | Request from the bridge itself |
| en_mask | input | N_EXT | Per-requester enable, 1 = may be granted |
| hi_grp | input | N_EXT | Per-requester group select, 1 = high, 0 = low |
| gnt_ext | output | N_EXT | Grant lines to the external masters |
| gnt_own | output | 1 | Grant to the bridge (also the rest position) |

## Verification
The table drives several request patterns. An all-high group with two requesters separates a true rotation from a fixed lowest-index choice. A mix of high and low requesters shows whether the low slot lands in the right place in the high ring and whether the low pointer wraps correctly. Busy-bus steps with the owner still requesting separate a held grant from early re-arbitration. A busy-bus step where the owner has dropped its request shows that release alone is enough to move the grant. A saturating run with all nine lines requesting and a single low member measures the worst-case wait of the low group. Strap and mask toggles check that grants are cut off in the same cycle and that parking on the bridge line is chosen over any masked request.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;

   // Index width for a ring of n members, never below one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sbarb_rr_pick.sv
module sbarb_rr_pick #(
   parameter int unsigned W = 4,
   localparam int unsigned IW = sbarb_pkg::idx_w(W)
) (
   input  logic [W-1:0]  req,
   input  logic [IW-1:0] last,
   output logic [IW-1:0] win,
   output logic          hit
);

   // First set request strictly after 'last', wrapping round the ring.
   always_comb begin
      win = '0;
      hit = 1'b0;
      for (int unsigned k = 1; k <= W; k++) begin
         int unsigned pos;
         pos = (32'(last) + k) % W;
         if (!hit && req[pos]) begin
            hit = 1'b1;
            win = IW'(pos);
         end
      end
   end

endmodule

// File: rtl/sbarb_decide.sv
module sbarb_decide #(
   parameter int unsigned N_EXT = 9,
   localparam int unsigned HW = N_EXT + 2,
   localparam int unsigned HIW = sbarb_pkg::idx_w(HW),
   localparam int unsigned LIW = sbarb_pkg::idx_w(N_EXT)
) (
   input  logic [N_EXT-1:0] elig_ext,
   input  logic [N_EXT-1:0] hi_grp,
   input  logic             own_req,
   input  logic [HIW-1:0]   hptr,
   input  logic [LIW-1:0]   lptr,
   output logic [N_EXT-1:0] nxt_ext,
   output logic             nxt_own,
   output logic [HIW-1:0]   hptr_n,
   output logic [LIW-1:0]   lptr_n
);

   localparam int unsigned OWN_POS  = N_EXT;
   localparam int unsigned SLOT_POS = N_EXT + 1;

   logic [N_EXT-1:0] lreq;
   logic [HW-1:0]    hreq;
   logic [HIW-1:0]   h_win;
   logic             h_hit;
   logic [LIW-1:0]   l_win;
   logic             l_hit;

   assign lreq = elig_ext & ~hi_grp;
   assign hreq = {|lreq, own_req, elig_ext & hi_grp};

   sbarb_rr_pick #(.W(HW)) u_hi_ring (
      .req (hreq),
      .last(hptr),
      .win (h_win),
      .hit (h_hit)
   );

   sbarb_rr_pick #(.W(N_EXT)) u_lo_ring (
      .req (lreq),
      .last(lptr),
      .win (l_win),
      .hit (l_hit)
   );

   always_comb begin
      nxt_ext = '0;
      nxt_own = 1'b0;
      hptr_n  = hptr;
      lptr_n  = lptr;
      if (!h_hit) begin
         nxt_own = 1'b1;                     // rest on the bridge line
      end else begin
         hptr_n = h_win;
         if (h_win == HIW'(SLOT_POS)) begin
            if (l_hit) begin
               nxt_ext[l_win] = 1'b1;
               lptr_n         = l_win;
            end
         end else if (h_win == HIW'(OWN_POS)) begin
            nxt_own = 1'b1;
         end else begin
            nxt_ext[h_win] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/sbarb_top.sv
module sbarb_top #(
   parameter int unsigned N_EXT = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arb_en,
   input  logic             bus_idle,
   input  logic [N_EXT-1:0] req_ext,
   input  logic             req_own,
   input  logic [N_EXT-1:0] en_mask,
   input  logic [N_EXT-1:0] hi_grp,
   output logic [N_EXT-1:0] gnt_ext,
   output logic             gnt_own
);

   localparam int unsigned HW       = N_EXT + 2;
   localparam int unsigned HIW      = sbarb_pkg::idx_w(HW);
   localparam int unsigned LIW      = sbarb_pkg::idx_w(N_EXT);
   localparam int unsigned SLOT_POS = N_EXT + 1;

   generate
      if (N_EXT < 2 || N_EXT > 30) begin : g_bad_n_ext
         $error("sbarb_top: N_EXT must lie in 2..30");
      end
   endgenerate

   logic [N_EXT-1:0] elig;
   logic [N_EXT-1:0] gnt_ext_q;
   logic [N_EXT-1:0] nxt_ext;
   logic             gnt_own_q;
   logic             nxt_own;
   logic [HIW-1:0]   hptr_q;
   logic [HIW-1:0]   hptr_n;
   logic [LIW-1:0]   lptr_q;
   logic [LIW-1:0]   lptr_n;
   logic             owner_live;
   logic             may_switch;

   // Per-line qualification and output gating.
   generate
      for (genvar i = 0; i < N_EXT; i++) begin : g_line
         assign elig[i]    = req_ext[i] & en_mask[i];
         assign gnt_ext[i] = gnt_ext_q[i] & en_mask[i] & arb_en;
      end
   endgenerate
   assign gnt_own = gnt_own_q & arb_en;

   assign owner_live = (|(gnt_ext_q & elig)) | (gnt_own_q & req_own);
   assign may_switch = bus_idle | ~owner_live;

   sbarb_decide #(.N_EXT(N_EXT)) u_decide (
      .elig_ext(elig),
      .hi_grp  (hi_grp),
      .own_req (req_own),
      .hptr    (hptr_q),
      .lptr    (lptr_q),
      .nxt_ext (nxt_ext),
      .nxt_own (nxt_own),
      .hptr_n  (hptr_n),
      .lptr_n  (lptr_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_ext_q <= '0;
         gnt_own_q <= 1'b1;
         hptr_q    <= HIW'(SLOT_POS);
         lptr_q    <= LIW'(N_EXT - 1);
      end else if (!arb_en) begin
         gnt_ext_q <= '0;
         gnt_own_q <= 1'b0;
      end else if (may_switch) begin
         gnt_ext_q <= nxt_ext;
         gnt_own_q <= nxt_own;
         hptr_q    <= hptr_n;
         lptr_q    <= lptr_n;
      end
   end

endmodule

// File: rtl/sbarb_chk.sv
module sbarb_chk #(
   parameter int unsigned N_EXT = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arb_en,
   input logic             bus_idle,
   input logic [N_EXT-1:0] req_ext,
   input logic             req_own,
   input logic [N_EXT-1:0] en_mask,
   input logic [N_EXT-1:0] gnt_ext,
   input logic             gnt_own
);

   assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_ext, gnt_own}));

   assert_strap_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_en |-> (gnt_ext == '0 && !gnt_own));

   assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ext & ~en_mask) == '0);

   assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && !bus_idle && (|(gnt_ext & req_ext)))
      |=> (!arb_en || gnt_ext == ($past(gnt_ext) & en_mask)));

   assert_park_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en && $past(arb_en) && $past(((req_ext & en_mask) == '0) && !req_own))
      |-> (gnt_own && gnt_ext == '0));

endmodule

bind sbarb_top sbarb_chk #(.N_EXT(N_EXT)) u_sbarb_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arb_en  (arb_en),
   .bus_idle(bus_idle),
   .req_ext (req_ext),
   .req_own (req_own),
   .en_mask (en_mask),
   .gnt_ext (gnt_ext),
   .gnt_own (gnt_own)
);

// File: tb/test_sbarb_top.sv
module test_sbarb_top;

   localparam int unsigned N = 9;

   typedef struct packed {
      logic         arb_en;
      logic         idle;
      logic         own;
      logic [N-1:0] req;
      logic [N-1:0] en;
      logic [N-1:0] hi;
      logic [N-1:0] x_ext;
      logic         x_own;
      logic [3:0]   rq;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 1'b1, 1'b0, 9'h000, 9'h1FF, 9'h1FF, 9'h000, 1'b1, 4'd9 },  // R9 park
      '{1'b1, 1'b1, 1'b0, 9'h006, 9'h1FF, 9'h1FF, 9'h002, 1'b0, 4'd4 },  // R4 first after reset ptr
      '{1'b1, 1'b0, 1'b0, 9'h006, 9'h1FF, 9'h1FF, 9'h002, 1'b0, 4'd7 },  // R7 hold busy
      '{1'b1, 1'b1, 1'b0, 9'h006, 9'h1FF, 9'h1FF, 9'h004, 1'b0, 4'd4 },  // R4 rotate
      '{1'b1, 1'b1, 1'b0, 9'h006, 9'h1FF, 9'h1FF, 9'h002, 1'b0, 4'd4 },  // R4 wrap
      '{1'b1, 1'b0, 1'b0, 9'h004, 9'h1FF, 9'h1FF, 9'h004, 1'b0, 4'd8 },  // R8 owner drop
      '{1'b1, 1'b1, 1'b0, 9'h062, 9'h1FF, 9'h00F, 9'h020, 1'b0, 4'd6 },  // R6 low slot
      '{1'b1, 1'b1, 1'b0, 9'h062, 9'h1FF, 9'h00F, 9'h002, 1'b0, 4'd4 },  // R4
      '{1'b1, 1'b1, 1'b0, 9'h062, 9'h1FF, 9'h00F, 9'h040, 1'b0, 4'd5 },  // R5
      '{1'b1, 1'b1, 1'b0, 9'h062, 9'h1FF, 9'h00F, 9'h002, 1'b0, 4'd4 },  // R4
      '{1'b1, 1'b1, 1'b0, 9'h062, 9'h1FF, 9'h00F, 9'h020, 1'b0, 4'd5 },  // R5 low wrap
      '{1'b1, 1'b1, 1'b0, 9'h062, 9'h1FD, 9'h00F, 9'h040, 1'b0, 4'd2 },  // R2 masked skipped
      '{1'b1, 1'b1, 1'b1, 9'h000, 9'h1FF, 9'h00F, 9'h000, 1'b1, 4'd4 },  // R4 own member
      '{1'b0, 1'b1, 1'b0, 9'h002, 9'h1FF, 9'h00F, 9'h000, 1'b0, 4'd1 },  // R1 strap off
      '{1'b1, 1'b1, 1'b0, 9'h002, 9'h1FF, 9'h00F, 9'h002, 1'b0, 4'd1 },  // R1 resume
      '{1'b1, 1'b0, 1'b0, 9'h002, 9'h1FD, 9'h00F, 9'h000, 1'b1, 4'd2 }   // R2 owner masked
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         arb_en = 1'b1;
   logic         bus_idle = 1'b1;
   logic [N-1:0] req_ext = '0;
   logic         req_own = 1'b0;
   logic [N-1:0] en_mask = '1;
   logic [N-1:0] hi_grp = '1;
   logic [N-1:0] gnt_ext;
   logic         gnt_own;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sbarb_top #(.N_EXT(N)) i_sbarb_top (
      .clk     (clk),
      .rst_n   (rst_n),
      .arb_en  (arb_en),
      .bus_idle(bus_idle),
      .req_ext (req_ext),
      .req_own (req_own),
      .en_mask (en_mask),
      .hi_grp  (hi_grp),
      .gnt_ext (gnt_ext),
      .gnt_own (gnt_own)
   );

   task automatic check_gnt(input string tag, input logic [N-1:0] x_ext, input logic x_own);
      checks++;
      if (gnt_ext !== x_ext || gnt_own !== x_own) begin
         errors++;
         $display("FAIL %s: gnt_ext=%03h gnt_own=%0b expected gnt_ext=%03h gnt_own=%0b",
                  tag, gnt_ext, gnt_own, x_ext, x_own);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   initial begin
      int wait_lo;
      int max_wait;
      logic [N-1:0] seen;
      do_reset();
      // R10: parked on the bridge line out of reset
      check_gnt("R10 reset", '0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         arb_en   = TBL[i].arb_en;
         bus_idle = TBL[i].idle;
         req_own  = TBL[i].own;
         req_ext  = TBL[i].req;
         en_mask  = TBL[i].en;
         hi_grp   = TBL[i].hi;
         step();
         check_gnt($sformatf("R%0d vec%0d", TBL[i].rq, i), TBL[i].x_ext, TBL[i].x_own);
      end

      // R10 and R11: fresh reset, all lines request; first pick is index 0, one edge later
      arb_en = 1'b1; bus_idle = 1'b0; req_own = 1'b0;
      req_ext = '0; en_mask = '1; hi_grp = '1;
      do_reset();
      req_ext = '1;
      #1;
      check_gnt("R11 before edge", '0, 1'b1);
      step();
      check_gnt("R10 first pick index 0", 9'h001, 1'b0);

      // R6 and R3: saturating load, only line 8 in the low group
      hi_grp = 9'h0FF;
      bus_idle = 1'b1;
      wait_lo = 0; max_wait = 0; seen = 9'h001;
      for (int c = 0; c < 30; c++) begin
         step();
         checks++;
         if ($countones({gnt_ext, gnt_own}) > 1) begin
            errors++;
            $display("FAIL R3: grants=%03h own=%0b expected at most one", gnt_ext, gnt_own);
         end
         seen |= gnt_ext;
         wait_lo++;
         if (gnt_ext[8]) begin
            if (wait_lo > max_wait) max_wait = wait_lo;
            wait_lo = 0;
         end
      end
      checks++;
      if (max_wait == 0 || max_wait > N + 1) begin
         errors++;
         $display("FAIL R6: low-group wait=%0d expected 1..%0d", max_wait, N + 1);
      end
      checks++;
      if (seen !== 9'h1FF) begin
         errors++;
         $display("FAIL R4: served set=%03h expected 1ff", seen);
      end

      // R8: owner drops with bus busy, grant moves to the next pending line
      bus_idle = 1'b0;
      req_ext = 9'h001;
      hi_grp = '1;
      step();
      step();
      check_gnt("R8 settle", 9'h001, 1'b0);
      req_ext = 9'h010;
      step();
      check_gnt("R8 busy release", 9'h010, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule